// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block collects level-sensitive interrupt request lines from several peripherals and presents one interrupt line to a processor. Software programs it through byte-wide memory-mapped registers: a channel mask, one vector index per channel, and a control register. The control register holds a global enable and a bit that selects the arbitration mode.

When the processor acknowledges the interrupt, the block picks one eligible channel. It pulses that channel's acknowledge line and returns the channel's programmed index on a vector bus with a valid strobe. The processor uses this index as the entry number in its interrupt table in memory. The grant is held until the processor drops its acknowledge.

Two arbitration modes are available. Fixed mode always prefers the lowest-numbered channel. Rotating mode starts the search just after the channel granted most recently. A channel that has been granted is not granted again until its request has gone low at least once.

Top module: `vectorIrqArbiter`

## Requirements
- R1: `cpuInt` is high one clock after the arbiter is enabled (control bit 0 set) and at least one channel is eligible. A channel is eligible when its request is high, its mask bit is set and it is not blocked as already serviced. Otherwise `cpuInt` is low.
- R2: When `cpuIntAck` is sampled high while no grant is active and some channel is eligible, exactly one bit of `irqAck` rises on the next clock. That bit belongs to a channel whose request was high.
- R3: With control bit 1 clear (fixed mode), the lowest-numbered eligible channel wins, so channel 0 beats channel 1.
- R4: With control bit 1 set (rotating mode), the search begins at the channel after the last granted one and wraps around. The channel just serviced therefore has the lowest priority.
- R5: While a grant is active, `vecValid` is high and `vecData` equals the index register of the granted channel.
- R6: The grant (`irqAck`, `vecData`, `vecValid`) stays unchanged while `cpuIntAck` is high. It clears on the clock after `cpuIntAck` is sampled low.
- R7: Register map, with BASE = `BASE_ADDR`:
  - BASE+0 is the mask, where bit n enables channel n.
  - BASE+1+n is the index of channel n.
  - BASE+1+NUM_CH is control, where bit 0 is enable and bit 1 is rotate.
  - Writes to any other address change nothing.
- R8: A granted channel stays ineligible until its request has been sampled low. An acknowledge that arrives while no channel is eligible grants nothing.
- R9: A channel whose mask bit is clear neither raises `cpuInt` nor is granted.
- R10: After reset all registers are zero, and `cpuInt`, `irqAck`, `vecValid` and `vecData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register write address |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | DATA_W | Register write data |
| irqReq | input | NUM_CH | Level-sensitive requests, bit n = channel n |
| cpuIntAck | input | 1 | Processor interrupt acknowledge |
| cpuInt | output | 1 | Interrupt to the processor |
| irqAck | output | NUM_CH | One-hot acknowledge to the granted channel |
| vecData | output | DATA_W | Index of the granted channel |
| vecValid | output | 1 | vecData is valid |

## Verification
The grant path is exercised with several request patterns:
- Simultaneous requests in fixed mode show whether the priority order is right.
- The same patterns in rotating mode, after first one channel and then the other was served, separate a rotating pointer from a fixed one.
- Requests that stay high after service, and a request that drops and rises again, show whether the serviced block is lifted only by a low level.
- A request on a masked channel, writes before the enable, and a write just past the last register show whether gating and address decode are in the right place.
- Reprogramming an index between grants shows whether the vector comes from the live register.

// File: rtl/vecArbPkg.sv
package vecArbPkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_GRANT = 1'b1
  } arbState_t;

  typedef struct packed {
    logic grantLoad;
    logic grantClear;
  } arbStrobes_t;

endpackage

// File: rtl/vecArbPicker.sv
module vecArbPicker #(
  parameter int NUM_CH = 2,
  parameter int IDX_W  = 1
) (
  input  logic [NUM_CH-1:0] eligible,
  input  logic              rotate,
  input  logic [IDX_W-1:0]  lastGrant,
  output logic [NUM_CH-1:0] winOnehot,
  output logic [IDX_W-1:0]  winIdx,
  output logic              anyWin
);

  int startPos;
  int pos;

  always_comb begin
    winOnehot = '0;
    winIdx    = '0;
    anyWin    = 1'b0;
    startPos  = 0;
    pos       = 0;
    if (rotate) begin
      startPos = int'(lastGrant) + 1;
      if (startPos >= NUM_CH) startPos = 0;
    end
    for (int k = 0; k < NUM_CH; k++) begin
      pos = startPos + k;
      if (pos >= NUM_CH) pos = pos - NUM_CH;
      if (!anyWin && eligible[pos]) begin
        anyWin         = 1'b1;
        winOnehot[pos] = 1'b1;
        winIdx         = IDX_W'(pos);
      end
    end
  end

endmodule

// File: rtl/vecArbControl.sv
module vecArbControl
  import vecArbPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuIntAck,
  input  logic        enable,
  input  logic        anyWin,
  output arbStrobes_t strobes
);

  arbState_t state, stateNext;

  always_comb begin
    stateNext          = state;
    strobes.grantLoad  = 1'b0;
    strobes.grantClear = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cpuIntAck && enable && anyWin) begin
          strobes.grantLoad = 1'b1;
          stateNext         = ST_GRANT;
        end
      end
      ST_GRANT: begin
        if (!cpuIntAck) begin
          strobes.grantClear = 1'b1;
          stateNext          = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/vecArbDatapath.sv
module vecArbDatapath
  import vecArbPkg::*;
#(
  parameter int                NUM_CH    = 2,
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 16,
  parameter int                IDX_W     = 1,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [NUM_CH-1:0] irqReq,
  input  arbStrobes_t       strobes,
  output logic              anyWin,
  output logic              enable,
  output logic              cpuInt,
  output logic [NUM_CH-1:0] irqAck,
  output logic [DATA_W-1:0] vecData,
  output logic              vecValid
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = BASE_ADDR + ADDR_W'(NUM_CH + 1);

  logic [NUM_CH-1:0] maskReg;
  logic [DATA_W-1:0] idxReg [NUM_CH];
  logic              enableReg;
  logic              rotateReg;
  logic [NUM_CH-1:0] servicedReg;
  logic [IDX_W-1:0]  lastGrant;
  logic [NUM_CH-1:0] eligible;
  logic [NUM_CH-1:0] winOnehot;
  logic [IDX_W-1:0]  winIdx;

  assign eligible = irqReq & maskReg & ~servicedReg;
  assign enable   = enableReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg   <= '0;
      enableReg <= 1'b0;
      rotateReg <= 1'b0;
    end else if (busWrEn) begin
      if (busAddr == BASE_ADDR) maskReg <= busWrData[NUM_CH-1:0];
      if (busAddr == CTRL_ADDR) begin
        enableReg <= busWrData[0];
        rotateReg <= busWrData[1];
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_idx
    localparam logic [ADDR_W-1:0] IDX_ADDR = BASE_ADDR + ADDR_W'(ch + 1);
    always_ff @(posedge clk) begin
      if (!rstN)                                idxReg[ch] <= '0;
      else if (busWrEn && busAddr == IDX_ADDR)  idxReg[ch] <= busWrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                                        servicedReg[ch] <= 1'b0;
      else if (strobes.grantLoad && winOnehot[ch])      servicedReg[ch] <= 1'b1;
      else if (!irqReq[ch])                             servicedReg[ch] <= 1'b0;
    end
  end

  vecArbPicker #(
    .NUM_CH (NUM_CH),
    .IDX_W  (IDX_W)
  ) u_picker (
    .eligible  (eligible),
    .rotate    (rotateReg),
    .lastGrant (lastGrant),
    .winOnehot (winOnehot),
    .winIdx    (winIdx),
    .anyWin    (anyWin)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqAck    <= '0;
      vecData   <= '0;
      vecValid  <= 1'b0;
      lastGrant <= '0;
      cpuInt    <= 1'b0;
    end else begin
      cpuInt <= enableReg && (eligible != '0);
      if (strobes.grantLoad) begin
        irqAck    <= winOnehot;
        vecData   <= idxReg[winIdx];
        vecValid  <= 1'b1;
        lastGrant <= winIdx;
      end else if (strobes.grantClear) begin
        irqAck   <= '0;
        vecData  <= '0;
        vecValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vectorIrqArbiter.sv
module vectorIrqArbiter
  import vecArbPkg::*;
#(
  parameter int                NUM_CH    = 2,
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [NUM_CH-1:0] irqReq,
  input  logic              cpuIntAck,
  output logic              cpuInt,
  output logic [NUM_CH-1:0] irqAck,
  output logic [DATA_W-1:0] vecData,
  output logic              vecValid
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  arbStrobes_t strobes;
  logic        anyWin;
  logic        enable;

  vecArbControl u_control (
    .clk       (clk),
    .rstN      (rstN),
    .cpuIntAck (cpuIntAck),
    .enable    (enable),
    .anyWin    (anyWin),
    .strobes   (strobes)
  );

  vecArbDatapath #(
    .NUM_CH    (NUM_CH),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .irqReq    (irqReq),
    .strobes   (strobes),
    .anyWin    (anyWin),
    .enable    (enable),
    .cpuInt    (cpuInt),
    .irqAck    (irqAck),
    .vecData   (vecData),
    .vecValid  (vecValid)
  );

endmodule

// File: rtl/vecArbChecker.sv
module vecArbChecker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] irqReq,
  input logic              cpuIntAck,
  input logic              cpuInt,
  input logic [NUM_CH-1:0] irqAck,
  input logic              vecValid
);

  assert_ack_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqAck));

  assert_ack_to_requester_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqAck) == '0 && irqAck != '0) |-> ((irqAck & $past(irqReq)) == irqAck));

  assert_grant_after_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqAck) == '0 && irqAck != '0) |-> $past(cpuIntAck));

  assert_grant_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqAck) != '0 && irqAck != '0) |-> (irqAck == $past(irqAck)));

  assert_grant_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck != '0 && !cpuIntAck) |=> (irqAck == '0));

  assert_valid_tracks_grant_R5: assert property (@(posedge clk) disable iff (!rstN)
    vecValid == (irqAck != '0));

  assert_int_needs_request_R1: assert property (@(posedge clk) disable iff (!rstN)
    cpuInt |-> ($past(irqReq) != '0));

endmodule

bind vectorIrqArbiter vecArbChecker #(.NUM_CH(NUM_CH)) u_vecArbChecker (
  .clk       (clk),
  .rstN      (rstN),
  .irqReq    (irqReq),
  .cpuIntAck (cpuIntAck),
  .cpuInt    (cpuInt),
  .irqAck    (irqAck),
  .vecValid  (vecValid)
);

// File: tb/test_vectorIrqArbiter.sv
module test_vectorIrqArbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 2;

  typedef struct {
    logic [NUM_CH-1:0] ack;
    logic [7:0]        vec;
    string             tag;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [15:0]       busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [7:0]        busWrData = '0;
  logic [NUM_CH-1:0] irqReq = '0;
  logic              cpuIntAck = 1'b0;
  logic              cpuInt;
  logic [NUM_CH-1:0] irqAck;
  logic [7:0]        vecData;
  logic              vecValid;

  int       checkCount = 0;
  int       failCount  = 0;
  expItem_t expQ[$];
  logic     prevValid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vectorIrqArbiter i_vectorIrqArbiter (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .irqReq    (irqReq),
    .cpuIntAck (cpuIntAck),
    .cpuInt    (cpuInt),
    .irqAck    (irqAck),
    .vecData   (vecData),
    .vecValid  (vecValid)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] addr, input logic [7:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = '0; busWrData = '0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Driver: queues the expected grant, then runs one acknowledge handshake
  task automatic grantCycle(input logic [NUM_CH-1:0] expAck, input logic [7:0] expVec,
                            input string tag);
    expQ.push_back('{ack: expAck, vec: expVec, tag: tag});
    @(negedge clk);
    cpuIntAck = 1'b1;
    repeat (3) @(negedge clk);
    check(irqAck == expAck, {"R6 grant held: ", tag}, irqAck, expAck);
    cpuIntAck = 1'b0;
    @(negedge clk);
    check(irqAck == '0 && !vecValid, {"R6 release: ", tag}, {vecValid, irqAck}, 0);
    @(negedge clk);
  endtask

  task automatic ackExpectNone(input string tag);
    @(negedge clk);
    cpuIntAck = 1'b1;
    repeat (3) @(negedge clk);
    check(irqAck == '0 && !vecValid, tag, {vecValid, irqAck}, 0);
    cpuIntAck = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: compares each new grant with the head of the queue
  always @(negedge clk) begin
    if (rstN && vecValid && !prevValid) begin
      if (expQ.size() == 0) begin
        checkCount++;
        failCount++;
        $display("FAIL R2 unexpected grant actual=0x%0h expected=0x0", irqAck);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(irqAck == e.ack, {"R2/R3/R4 granted channel: ", e.tag}, irqAck, e.ack);
        check(vecData == e.vec, {"R5 vector: ", e.tag}, vecData, e.vec);
      end
    end
    prevValid = vecValid;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!cpuInt && irqAck == '0 && !vecValid && vecData == '0, "R10 reset outputs",
          {cpuInt, vecValid, irqAck, vecData}, 0);
    rstN = 1'b1;

    // Requests before configuration; stray write one past control
    irqReq = 2'b11;
    busWrite(16'hFFF4, 8'h01);
    busWrite(16'hFFF0, 8'h03);
    busWrite(16'hFFF1, 8'd13);
    busWrite(16'hFFF2, 8'd17);
    settle();
    check(!cpuInt, "R1 disabled after reset", cpuInt, 0);
    check(!cpuInt, "R7 write past control ignored", cpuInt, 0);

    busWrite(16'hFFF3, 8'h01);
    settle();
    check(cpuInt, "R1 enabled with requests", cpuInt, 1);

    grantCycle(2'b01, 8'd13, "R3 fixed both request, ch0");
    settle();
    check(cpuInt, "R1 ch1 still pending", cpuInt, 1);
    grantCycle(2'b10, 8'd17, "R3 fixed remaining ch1");
    settle();
    check(!cpuInt, "R8 both serviced, no interrupt", cpuInt, 0);
    ackExpectNone("R8 ack with nothing eligible");

    irqReq = 2'b10;
    settle();
    irqReq = 2'b11;
    settle();
    check(cpuInt, "R8 ch0 re-armed after low", cpuInt, 1);
    grantCycle(2'b01, 8'd13, "R8 ch0 granted again");

    irqReq = 2'b00;
    settle();
    busWrite(16'hFFF0, 8'h02);
    irqReq = 2'b01;
    settle();
    check(!cpuInt, "R9 masked ch0 no interrupt", cpuInt, 0);
    ackExpectNone("R9 masked ch0 not granted");
    irqReq = 2'b11;
    settle();
    grantCycle(2'b10, 8'd17, "R9 only unmasked ch1");
    irqReq = 2'b00;
    settle();

    busWrite(16'hFFF0, 8'h03);
    busWrite(16'hFFF1, 8'hA5);
    busWrite(16'hFFF3, 8'h03);
    irqReq = 2'b01;
    settle();
    grantCycle(2'b01, 8'hA5, "R5 reprogrammed index ch0");
    irqReq = 2'b00;
    settle();
    irqReq = 2'b11;
    settle();
    grantCycle(2'b10, 8'd17, "R4 rotate after ch0 picks ch1");
    grantCycle(2'b01, 8'hA5, "R4 then ch0");
    irqReq = 2'b00;
    settle();
    irqReq = 2'b11;
    settle();
    grantCycle(2'b10, 8'd17, "R4 rotate after ch0 again ch1");
    irqReq = 2'b00;
    settle();
    irqReq = 2'b11;
    settle();
    grantCycle(2'b01, 8'hA5, "R4 rotate after ch1 picks ch0");

    busWrite(16'hFFF3, 8'h01);
    irqReq = 2'b00;
    settle();
    irqReq = 2'b11;
    settle();
    grantCycle(2'b01, 8'hA5, "R3 fixed again ch0 after ch0");

    busWrite(16'hFFF3, 8'h00);
    settle();
    check(!cpuInt, "R1 disabled with eligible request", cpuInt, 0);

    check(expQ.size() == 0, "R2 all expected grants seen", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule